// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a 4608-bit embedded memory with one write port and one read port. Each port runs on its own clock and has its own enable. Its shape is fixed by a parameter: 18, 9, 4, 2 or 1 bits wide. Both ports address the same storage, so a word written at one width can be read back at another. The block splits each address into a storage row and a bit lane within that row. It writes only the lane that was addressed and picks the matching lane on the read side.

There are two shape families. The parity-capable family (9 and 18 bits) uses every one of the 4608 bits: an 18-bit word is a pair of adjacent 9-bit words. The plain family (1, 2 and 4 bits) uses a 4096-bit linear space in which narrow word k covers bits k*w up to k*w+w-1. A port from one family cannot be paired with a port from the other, and such a pairing stops elaboration.

Top module: `mwr_dpram`

## Requirements
- R1: The legal widths are 1, 2, 4, 9 and 18. The depth is 4096/w for the plain family (4096, 2048, 1024) and 4608/w for the parity-capable family (512, 256). Each port's address width is log2 of its depth.
- R2: In the plain family, narrow word k occupies linear bits [k*w +: w]. So a 4-bit word written at address a is read through a 1-bit port at addresses 4a..4a+3, least significant bit first.
- R3: In the parity-capable family, the 18-bit word at address a equals {9-bit word 2a+1, 9-bit word 2a}. Bits [8:0] map to address 2a and bits [17:9] to address 2a+1.
- R4: A read is synchronous. When rd_en is high at a rising rd_clk edge, rd_data shows the addressed word right after that edge and not before it.
- R5: While rd_en is low at a rising rd_clk edge, rd_data keeps its value, whatever rd_addr does.
- R6: A write needs wr_en high at a rising wr_clk edge. It changes only the wr_width bits of the addressed word and leaves neighbouring words in the same row unchanged. With wr_en low, nothing is written.
- R7: When a read and a write hit the same location at the same clock edge, the read returns the data held before the write.
- R8: When rd_rst_n is low at a rising rd_clk edge, rd_data is cleared to zero. While wr_rst_n is low at a rising wr_clk edge, no write takes place.
- R9: An illegal width, or a pairing of a parity-capable width with a plain width, stops elaboration with an error. The package legality check returns 0 for such pairs and 1 for legal ones.
- R10: The highest address of every shape is usable: 1023 at 4 bits, 4095 at 1 bit, 255 at 18 bits and 511 at 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Synchronous active-low write-side reset (blocks writes) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | WR_AW | Write word address |
| wr_data | input | WR_WIDTH | Write data |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low read-side reset (clears rd_data) |
| rd_en | input | 1 | Read enable |
| rd_addr | input | RD_AW | Read word address |
| rd_data | output | RD_WIDTH | Registered read data |

## Verification
The bench writes 4-bit words into lanes that share a storage row, then reads every bit back through a 1-bit port only after all writes are done. A lane decode that clobbers neighbouring words, or a lane order that is reversed, therefore shows up as wrong bits. A collision test reads and writes the same location at the same edge. A design that forwards write data would return the new bit there instead of the old one. The bench also checks that the read data does not change before the sampling edge and that a low rd_en holds it, which exposes a combinational read path and a free-running output register. On a second instance with 18-bit writes and 9-bit reads, including the top address, the bench catches swapped halves and a row range that falls short.

// File: rtl/mwr_pkg.sv
// Package: shape arithmetic shared by the mixed-width RAM.
// Assumes storage is 256 rows; a row is 18 bits for the parity-capable
// widths (9, 18) and 16 bits for the plain widths (1, 2, 4).
package mwr_pkg;

    localparam int unsigned ROW_COUNT  = 256;
    localparam int unsigned WIDE_ROW_W = 18;
    localparam int unsigned NARROW_ROW_W = 16;

    // True for one of the five supported port widths.
    function automatic bit shape_ok(input int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18);
    endfunction

    // True for the widths that carry the extra ninth bit.
    function automatic bit is_wide(input int unsigned w);
        return (w == 9) || (w == 18);
    endfunction

    // True when both widths are legal and belong to one family.
    function automatic bit pair_ok(input int unsigned a, input int unsigned b);
        return shape_ok(a) && shape_ok(b) && (is_wide(a) == is_wide(b));
    endfunction

    // Row width used by a port of width w.
    function automatic int unsigned row_bits(input int unsigned w);
        return is_wide(w) ? WIDE_ROW_W : NARROW_ROW_W;
    endfunction

    // Number of addressable words for a port of width w.
    function automatic int unsigned depth_of(input int unsigned w);
        return (row_bits(w) * ROW_COUNT) / w;
    endfunction

    // Width of a lane index for a given lane count (at least one bit).
    function automatic int unsigned sel_bits(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    // Number of address bits that select a lane (zero for one lane).
    function automatic int unsigned lane_addr_bits(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 0;
    endfunction

endpackage

// File: rtl/mwr_addr_map.sv
// Splits a word address into a storage row and a lane inside that row.
// Assumes ROW_W is a whole multiple of WIDTH and the lane count is a power of two.
// The low address bits select the lane, so consecutive words fill a row
// from bit 0 upward.
module mwr_addr_map #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned ROW_W = 16,
    parameter int unsigned ROWS  = 256,
    localparam int unsigned LANES  = ROW_W / WIDTH,
    localparam int unsigned ROW_AW = $clog2(ROWS),
    localparam int unsigned SEL_W  = mwr_pkg::sel_bits(LANES),
    localparam int unsigned ADDR_W = ROW_AW + mwr_pkg::lane_addr_bits(LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_AW-1:0] row,
    output logic [SEL_W-1:0]  lane
);

    generate
        if (LANES > 1) begin : g_multi
            // Upper bits pick the row, lower bits the lane.
            assign row  = addr[ADDR_W-1:SEL_W];
            assign lane = addr[SEL_W-1:0];
        end else begin : g_single
            // One word per row: the address is the row.
            assign row  = addr;
            assign lane = '0;
        end
    endgenerate

endmodule

// File: rtl/mwr_lane_dec.sv
// Turns a lane index and an enable into a one-hot lane write strobe.
// Assumes the lane index is always below LANES (true for power-of-two counts).
module mwr_lane_dec #(
    parameter int unsigned LANES = 4,
    localparam int unsigned SEL_W = mwr_pkg::sel_bits(LANES)
) (
    input  logic             en,
    input  logic [SEL_W-1:0] lane,
    output logic [LANES-1:0] strobe
);

    // Raise exactly one strobe bit when enabled.
    always_comb begin
        strobe = '0;
        if (en) begin
            strobe[lane] = 1'b1;
        end
    end

endmodule

// File: rtl/mwr_store.sv
// Row storage: per-lane writes on wr_clk, whole-row registered reads on rd_clk.
// Assumes the lane strobe is one-hot or zero. Same-edge collisions return
// the old row, because the write commits with a nonblocking assignment.
module mwr_store #(
    parameter int unsigned ROW_W    = 16,
    parameter int unsigned ROWS     = 256,
    parameter int unsigned WR_WIDTH = 4,
    localparam int unsigned WR_LANES = ROW_W / WR_WIDTH,
    localparam int unsigned ROW_AW   = $clog2(ROWS)
) (
    input  logic                wr_clk,
    input  logic [ROW_AW-1:0]   wr_row,
    input  logic [WR_LANES-1:0] wr_strobe,
    input  logic [WR_WIDTH-1:0] wr_data,
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    input  logic                rd_en,
    input  logic [ROW_AW-1:0]   rd_row,
    output logic [ROW_W-1:0]    row_q
);

    logic [ROW_W-1:0] mem [ROWS];

    // Write the strobed lane of the addressed row.
    always_ff @(posedge wr_clk) begin
        for (int i = 0; i < int'(WR_LANES); i++) begin
            if (wr_strobe[i]) begin
                mem[wr_row][i*WR_WIDTH +: WR_WIDTH] <= wr_data;
            end
        end
    end

    // Capture the addressed row when a read is requested.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            row_q <= '0;
        end else if (rd_en) begin
            row_q <= mem[rd_row];
        end
    end

endmodule

// File: rtl/mwr_lane_sel.sv
// Read-side lane register and output mux.
// Assumes row_q is updated on the same edges as the lane register here.
module mwr_lane_sel #(
    parameter int unsigned ROW_W    = 16,
    parameter int unsigned RD_WIDTH = 1,
    localparam int unsigned RD_LANES = ROW_W / RD_WIDTH,
    localparam int unsigned SEL_W    = mwr_pkg::sel_bits(RD_LANES)
) (
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    input  logic                rd_en,
    input  logic [SEL_W-1:0]    rd_lane,
    input  logic [ROW_W-1:0]    row_q,
    output logic [RD_WIDTH-1:0] rd_data
);

    logic [SEL_W-1:0] lane_q;

    // Remember which lane the captured row should be read from.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            lane_q <= '0;
        end else if (rd_en) begin
            lane_q <= rd_lane;
        end
    end

    // Pick the remembered lane out of the captured row.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(RD_LANES); i++) begin
            if (lane_q == SEL_W'(i)) begin
                rd_data = row_q[i*RD_WIDTH +: RD_WIDTH];
            end
        end
    end

    // R8
    rd_reset_zero_chk: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (rd_data == '0));

    // R5
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/mwr_dpram.sv
// Mixed-width dual-port RAM top: one write port, one read port, each
// with its own width drawn from {1,2,4,9,18} over 4608 bits of storage.
// Assumes both widths belong to the same family; otherwise elaboration stops.
module mwr_dpram #(
    parameter int unsigned WR_WIDTH = 4,
    parameter int unsigned RD_WIDTH = 1,
    localparam int unsigned WR_AW = $clog2(mwr_pkg::depth_of(WR_WIDTH)),
    localparam int unsigned RD_AW = $clog2(mwr_pkg::depth_of(RD_WIDTH))
) (
    input  logic                wr_clk,
    input  logic                wr_rst_n,
    input  logic                wr_en,
    input  logic [WR_AW-1:0]    wr_addr,
    input  logic [WR_WIDTH-1:0] wr_data,
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    input  logic                rd_en,
    input  logic [RD_AW-1:0]    rd_addr,
    output logic [RD_WIDTH-1:0] rd_data
);

    localparam int unsigned ROWS     = mwr_pkg::ROW_COUNT;
    localparam int unsigned ROW_W    = mwr_pkg::row_bits(WR_WIDTH);
    localparam int unsigned ROW_AW   = $clog2(ROWS);
    localparam int unsigned WR_LANES = ROW_W / WR_WIDTH;
    localparam int unsigned RD_LANES = ROW_W / RD_WIDTH;
    localparam int unsigned WR_SEL_W = mwr_pkg::sel_bits(WR_LANES);
    localparam int unsigned RD_SEL_W = mwr_pkg::sel_bits(RD_LANES);

    // R9: reject unsupported widths and cross-family pairings.
    generate
        if (!mwr_pkg::pair_ok(WR_WIDTH, RD_WIDTH)) begin : g_bad_shape
            $error("mwr_dpram: width pair %0d/%0d is not a legal shape pair",
                   WR_WIDTH, RD_WIDTH);
        end
    endgenerate

    logic [ROW_AW-1:0]   wr_row;
    logic [WR_SEL_W-1:0] wr_lane;
    logic [WR_LANES-1:0] wr_strobe;
    logic [ROW_AW-1:0]   rd_row;
    logic [RD_SEL_W-1:0] rd_lane;
    logic [ROW_W-1:0]    row_q;
    logic                wr_go;

    // Writes are allowed only outside write-side reset.
    assign wr_go = wr_en && wr_rst_n;

    mwr_addr_map #(.WIDTH(WR_WIDTH), .ROW_W(ROW_W), .ROWS(ROWS)) u_wr_map (
        .addr (wr_addr),
        .row  (wr_row),
        .lane (wr_lane)
    );

    mwr_lane_dec #(.LANES(WR_LANES)) u_wr_dec (
        .en     (wr_go),
        .lane   (wr_lane),
        .strobe (wr_strobe)
    );

    mwr_addr_map #(.WIDTH(RD_WIDTH), .ROW_W(ROW_W), .ROWS(ROWS)) u_rd_map (
        .addr (rd_addr),
        .row  (rd_row),
        .lane (rd_lane)
    );

    mwr_store #(.ROW_W(ROW_W), .ROWS(ROWS), .WR_WIDTH(WR_WIDTH)) u_store (
        .wr_clk    (wr_clk),
        .wr_row    (wr_row),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .rd_en     (rd_en),
        .rd_row    (rd_row),
        .row_q     (row_q)
    );

    mwr_lane_sel #(.ROW_W(ROW_W), .RD_WIDTH(RD_WIDTH)) u_rd_sel (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_lane  (rd_lane),
        .row_q    (row_q),
        .rd_data  (rd_data)
    );

    // R6
    wr_one_lane_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_en |-> ($countones(wr_strobe) == 1));

    // R6
    wr_idle_quiet_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_en |-> (wr_strobe == '0));

endmodule

// File: tb/sim_mwr_dpram.sv
`timescale 1ns/1ps
// Bench: u0 writes 4 bits and reads 1 bit; u1 writes 18 bits and reads 9 bits.
module sim_mwr_dpram;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic wr_rst_n, rd_rst_n;
    logic        w0_en, r0_en;
    logic [9:0]  w0_addr;
    logic [3:0]  w0_data;
    logic [11:0] r0_addr;
    logic [0:0]  r0_data;
    logic        w1_en, r1_en;
    logic [7:0]  w1_addr;
    logic [17:0] w1_data;
    logic [8:0]  r1_addr;
    logic [8:0]  r1_data;

    int checks = 0;
    int failures = 0;
    logic [4095:0] lin;

    mwr_dpram #(.WR_WIDTH(4), .RD_WIDTH(1)) u0 (
        .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_en(w0_en), .wr_addr(w0_addr),
        .wr_data(w0_data), .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_en(r0_en),
        .rd_addr(r0_addr), .rd_data(r0_data)
    );

    mwr_dpram #(.WR_WIDTH(18), .RD_WIDTH(9)) u1 (
        .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_en(w1_en), .wr_addr(w1_addr),
        .wr_data(w1_data), .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_en(r1_en),
        .rd_addr(r1_addr), .rd_data(r1_data)
    );

    // {4-bit word address, data}
    localparam logic [13:0] VEC [8] = '{
        {10'd0,    4'hA}, {10'd1,   4'h3}, {10'd2,   4'hF}, {10'd3,   4'h0},
        {10'd512,  4'h5}, {10'd1023, 4'h9}, {10'd100, 4'hC}, {10'd101, 4'h6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr0(input logic [9:0] a, input logic [3:0] d);
        @(negedge clk); w0_en = 1'b1; w0_addr = a; w0_data = d;
        @(negedge clk); w0_en = 1'b0;
        lin[a*4 +: 4] = d;
    endtask

    task automatic rd0(input logic [11:0] a, output logic [0:0] q);
        @(negedge clk); r0_en = 1'b1; r0_addr = a;
        @(negedge clk); r0_en = 1'b0; q = r0_data;
    endtask

    task automatic wr1(input logic [7:0] a, input logic [17:0] d);
        @(negedge clk); w1_en = 1'b1; w1_addr = a; w1_data = d;
        @(negedge clk); w1_en = 1'b0;
    endtask

    task automatic rd1(input logic [8:0] a, output logic [8:0] q);
        @(negedge clk); r1_en = 1'b1; r1_addr = a;
        @(negedge clk); r1_en = 1'b0; q = r1_data;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 4);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [0:0] b;
        logic [8:0] h;
        logic [17:0] wd [3];
        logic [7:0]  wa [3];
        lin = '0;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        w0_en = 0; r0_en = 0; w0_addr = 0; w0_data = 0; r0_addr = 0;
        w1_en = 0; r1_en = 0; w1_addr = 0; w1_data = 0; r1_addr = 0;
        repeat (3) @(negedge clk);
        // R8: read data clear during reset
        check("R8 u0 reset rd_data", 32'(r0_data), 32'h0);
        check("R8 u1 reset rd_data", 32'(r1_data), 32'h0);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;

        // R1 / R9: shape arithmetic and legality
        check("R1 depth w4",  mwr_pkg::depth_of(4),  1024);
        check("R1 depth w1",  mwr_pkg::depth_of(1),  4096);
        check("R1 depth w9",  mwr_pkg::depth_of(9),  512);
        check("R1 depth w18", mwr_pkg::depth_of(18), 256);
        check("R9 pair 9/4",  32'(mwr_pkg::pair_ok(9, 4)),  0);
        check("R9 pair 3/3",  32'(mwr_pkg::pair_ok(3, 3)),  0);
        check("R9 pair 18/9", 32'(mwr_pkg::pair_ok(18, 9)), 1);
        check("R9 pair 4/1",  32'(mwr_pkg::pair_ok(4, 1)),  1);

        // R2 / R6 / R10: write all vectors, then read each bit back
        for (int i = 0; i < 8; i++) wr0(VEC[i][13:4], VEC[i][3:0]);
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 4; k++) begin
                rd0({VEC[i][13:4], 2'(k)}, b);
                check("R2 R6 R10 lane readback", 32'(b), 32'(VEC[i][k]));
            end
        end

        // R7: same-edge read and write of bit 0 returns old value
        @(negedge clk);
        w0_en = 1'b1; w0_addr = 10'd0; w0_data = 4'h5;
        r0_en = 1'b1; r0_addr = 12'd0;
        @(negedge clk);
        w0_en = 1'b0; r0_en = 1'b0;
        check("R7 collision old data", 32'(r0_data), 32'(lin[0]));
        lin[3:0] = 4'h5;
        rd0(12'd0, b);
        check("R7 new data after collision", 32'(b), 32'h1);

        // R5: rd_en low holds data while the address moves
        @(negedge clk); r0_addr = 12'd1;
        repeat (2) @(negedge clk);
        check("R5 hold with rd_en low", 32'(r0_data), 32'h1);

        // R4: no change before the edge, new word right after it
        @(negedge clk); r0_en = 1'b1; r0_addr = 12'd1;
        #1;
        check("R4 before edge", 32'(r0_data), 32'h1);
        @(negedge clk); r0_en = 1'b0;
        check("R4 after edge", 32'(r0_data), 32'(lin[1]));

        // R6: wr_en low writes nothing
        @(negedge clk); w0_addr = 10'd1; w0_data = 4'hF;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            rd0(12'(4 + k), b);
            check("R6 idle write ignored", 32'(b), 32'(lin[4 + k]));
        end

        // R8: write-side reset blocks a write
        @(negedge clk); wr_rst_n = 1'b0; w0_en = 1'b1; w0_addr = 10'd2; w0_data = 4'h0;
        @(negedge clk); wr_rst_n = 1'b1; w0_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            rd0(12'(8 + k), b);
            check("R8 write blocked in reset", 32'(b), 32'(lin[8 + k]));
        end

        // R8: read-side reset clears held data
        rd0(12'd8, b);
        @(negedge clk); rd_rst_n = 1'b0;
        @(negedge clk); rd_rst_n = 1'b1;
        check("R8 rd reset mid-run", 32'(r0_data), 32'h0);

        // R3 / R10: 18-bit words read as 9-bit halves
        wa[0] = 8'd0;   wd[0] = 18'h2C3A5;
        wa[1] = 8'd255; wd[1] = 18'h15A5F;
        wa[2] = 8'd7;   wd[2] = 18'h3FE01;
        for (int i = 0; i < 3; i++) wr1(wa[i], wd[i]);
        for (int i = 0; i < 3; i++) begin
            rd1({wa[i], 1'b0}, h);
            check("R3 R10 low half", 32'(h), 32'(wd[i][8:0]));
            rd1({wa[i], 1'b1}, h);
            check("R3 R10 high half", 32'(h), 32'(wd[i][17:9]));
        end

        finish_run();
    end

endmodule